// File: doc/BRIEF.md
# Qualified IO Address Decoder

This block is select logic for the IO space of a processor bus with an 8-bit IO address. It takes the low address byte, the bus control strobes (IO request, opcode fetch, read, write) and a bus-cycle-valid clock E. It produces one active-low select for expansion boards and one for a multi-function peripheral. For the peripheral it also produces read and write strobes and a 6-bit register offset. Every output is registered on the system clock, and all bus inputs are taken to be synchronous to that clock.

The peripheral latches its address when a strobe begins. For that reason its strobes are only driven while E is high, which is when the bus cycle is settled. An interrupt-acknowledge cycle drives IO request and opcode fetch low together, and that can look like an IO selection. An interlock catches that condition and holds every output inactive until IO request is released.

Top module: `io_qual_decoder`

## Requirements
- R1: A select or strobe is produced only for an IO cycle, meaning `iorq_n` is low and `m1_n` is high in the sampled cycle.
- R2: `exp_cs_n` is driven low for IO cycles whose address lies in 0x40..0x7F or in 0xC0..0xD7.
- R3: `per_cs_n` is driven low for IO cycles whose address lies in 0x80..0xBF.
- R4: Addresses 0x00..0x3F and 0xD8..0xFF drive no select and no strobe.
- R5: `per_off` equals address bits 5:0 whenever `per_cs_n` is low, and is zero otherwise.
- R6: `per_ior_n` is driven low only when the peripheral is selected, `e_clk` is high, `rd_n` is low and `wr_n` is high.
- R7: `per_iow_n` is driven low only when the peripheral is selected, `e_clk` is high, `wr_n` is low and `rd_n` is high.
- R8: If `rd_n` and `wr_n` are both low, both peripheral strobes stay high. The two strobes are never low together.
- R9: A cycle with `iorq_n` and `m1_n` both low sets an interlock. The interlock holds all selects and strobes inactive, with the offset at zero, as long as `iorq_n` stays low, even after `m1_n` returns high. It clears once `iorq_n` is sampled high.
- R10: Each output reflects the inputs sampled at the previous clock edge, so every output is inactive in the cycle after `iorq_n` is sampled high. A synchronous active-low `rst_n` clears the interlock and drives every output inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 8 | Low byte of the IO address |
| iorq_n | input | 1 | IO request, active low |
| m1_n | input | 1 | Opcode-fetch marker, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| e_clk | input | 1 | Bus-cycle-valid clock, high during the settled part of a cycle |
| exp_cs_n | output | 1 | Expansion board select, active low |
| per_cs_n | output | 1 | Peripheral select, active low |
| per_ior_n | output | 1 | Peripheral read strobe, active low |
| per_iow_n | output | 1 | Peripheral write strobe, active low |
| per_off | output | 6 | Peripheral register offset |

## Verification
The interlock and strobe qualification can act in the same cycle. The bench provokes this by raising `m1_n` while `iorq_n` stays low, with a peripheral address, a low `rd_n` and E high. A decoder that looks only at the current cycle would issue a read strobe there, but the latched acknowledge must keep everything high. The bench also raises `iorq_n` in the same cycle that the interlock would otherwise persist, and then starts a clean read straight after. It judges each cycle against a behavioural model that tracks the acknowledge state on its own.

// File: rtl/io_qual_pkg.sv
package io_qual_pkg;

    localparam int ADDR_W = 8;
    localparam int OFF_W  = 6;

    typedef struct packed {
        logic              exp_cs_n;
        logic              per_cs_n;
        logic              ior_n;
        logic              iow_n;
        logic [OFF_W-1:0]  off;
        logic              ack;
    } dec_state_t;

    localparam dec_state_t DEC_IDLE = '{
        exp_cs_n: 1'b1,
        per_cs_n: 1'b1,
        ior_n:    1'b1,
        iow_n:    1'b1,
        off:      '0,
        ack:      1'b0
    };

endpackage

// File: rtl/io_window_match.sv
module io_window_match #(
    parameter int                AW = 8,
    parameter logic [AW-1:0]     LO = '0,
    parameter logic [AW-1:0]     HI = '1
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    // Inclusive address window.
    always_comb begin
        hit = (addr >= LO) && (addr <= HI);
    end
endmodule

// File: rtl/io_ack_interlock.sv
module io_ack_interlock (
    input  logic iorq_n,
    input  logic m1_n,
    input  logic ack_q,
    output logic ack_d,
    output logic io_ok
);
    // An acknowledge (IO request together with opcode fetch) sets the
    // latch. The latch stays set until IO request is released.
    always_comb begin
        ack_d = !iorq_n && (!m1_n || ack_q);
        io_ok = !iorq_n && m1_n && !ack_q;
    end
endmodule

// File: rtl/io_strobe_qual.sv
module io_strobe_qual (
    input  logic sel,
    input  logic e_clk,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_go,
    output logic wr_go
);
    // Strobes only inside the settled part of the bus cycle, and never
    // when both data strobes claim the bus together.
    always_comb begin
        rd_go = sel && e_clk && !rd_n && wr_n;
        wr_go = sel && e_clk && !wr_n && rd_n;
    end
endmodule

// File: rtl/io_qual_decoder.sv
module io_qual_decoder
    import io_qual_pkg::*;
#(
    parameter int                 N_EXP  = 2,
    parameter logic [ADDR_W-1:0]  EXP_LO [N_EXP] = '{8'h40, 8'hC0},
    parameter logic [ADDR_W-1:0]  EXP_HI [N_EXP] = '{8'h7F, 8'hD7},
    parameter logic [ADDR_W-1:0]  PER_LO = 8'h80,
    parameter logic [ADDR_W-1:0]  PER_HI = 8'hBF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              iorq_n,
    input  logic              m1_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              e_clk,
    output logic              exp_cs_n,
    output logic              per_cs_n,
    output logic              per_ior_n,
    output logic              per_iow_n,
    output logic [OFF_W-1:0]  per_off
);

    dec_state_t state_d, state_q;

    logic [N_EXP-1:0] exp_hits;
    logic             exp_hit;
    logic             per_hit;
    logic             ack_d;
    logic             io_ok;
    logic             rd_go;
    logic             wr_go;

    // Expansion windows: one comparator per window.
    for (genvar gi = 0; gi < N_EXP; gi++) begin : g_exp_win
        io_window_match #(
            .AW (ADDR_W),
            .LO (EXP_LO[gi]),
            .HI (EXP_HI[gi])
        ) u_win (
            .addr (addr),
            .hit  (exp_hits[gi])
        );
    end

    io_window_match #(
        .AW (ADDR_W),
        .LO (PER_LO),
        .HI (PER_HI)
    ) u_per_win (
        .addr (addr),
        .hit  (per_hit)
    );

    io_ack_interlock u_lock (
        .iorq_n (iorq_n),
        .m1_n   (m1_n),
        .ack_q  (state_q.ack),
        .ack_d  (ack_d),
        .io_ok  (io_ok)
    );

    io_strobe_qual u_strb (
        .sel    (io_ok && per_hit),
        .e_clk  (e_clk),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .rd_go  (rd_go),
        .wr_go  (wr_go)
    );

    always_comb begin
        exp_hit = |exp_hits;

        state_d          = DEC_IDLE;
        state_d.ack      = ack_d;
        state_d.exp_cs_n = !(io_ok && exp_hit);
        state_d.per_cs_n = !(io_ok && per_hit);
        state_d.ior_n    = !rd_go;
        state_d.iow_n    = !wr_go;
        if (io_ok && per_hit) begin
            state_d.off = addr[OFF_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DEC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign exp_cs_n  = state_q.exp_cs_n;
    assign per_cs_n  = state_q.per_cs_n;
    assign per_ior_n = state_q.ior_n;
    assign per_iow_n = state_q.iow_n;
    assign per_off   = state_q.off;

endmodule

// File: rtl/io_qual_checker.sv
module io_qual_checker
    import io_qual_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              iorq_n,
    input logic              m1_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              e_clk,
    input logic              exp_cs_n,
    input logic              per_cs_n,
    input logic              per_ior_n,
    input logic              per_iow_n,
    input logic [OFF_W-1:0]  per_off
);

    // R8
    a_r8_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!per_ior_n && !per_iow_n));

    // R6
    a_r6_ior_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        !per_ior_n |-> !per_cs_n);

    // R7
    a_r7_iow_needs_e: assert property (@(posedge clk) disable iff (!rst_n)
        !per_iow_n |-> $past(e_clk));

    // R2 and R3: the windows never overlap
    a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!exp_cs_n, !per_cs_n}) <= 1);

    // R1
    a_r1_io_cycle_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!exp_cs_n || !per_cs_n) |-> $past(!iorq_n && m1_n));

    // R10
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        iorq_n |=> (exp_cs_n && per_cs_n && per_ior_n && per_iow_n));

    // R9
    a_r9_ack_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && !m1_n) |=> (exp_cs_n && per_cs_n && per_ior_n && per_iow_n));

    // R5
    a_r5_offset_track: assert property (@(posedge clk) disable iff (!rst_n)
        !per_cs_n |-> (per_off == $past(addr[OFF_W-1:0])));

endmodule

bind io_qual_decoder io_qual_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .iorq_n    (iorq_n),
    .m1_n      (m1_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .e_clk     (e_clk),
    .exp_cs_n  (exp_cs_n),
    .per_cs_n  (per_cs_n),
    .per_ior_n (per_ior_n),
    .per_iow_n (per_iow_n),
    .per_off   (per_off)
);

// File: tb/sim_io_qual_decoder.sv
module sim_io_qual_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       iorq_n = 1'b1;
    logic       m1_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       e_clk = 1'b0;
    logic       exp_cs_n, per_cs_n, per_ior_n, per_iow_n;
    logic [5:0] per_off;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // reference model state
    bit       m_ack = 1'b0;
    bit       x_exp = 1'b1, x_per = 1'b1, x_ior = 1'b1, x_iow = 1'b1;
    bit [5:0] x_off = 6'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_qual_decoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .iorq_n    (iorq_n),
        .m1_n      (m1_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .e_clk     (e_clk),
        .exp_cs_n  (exp_cs_n),
        .per_cs_n  (per_cs_n),
        .per_ior_n (per_ior_n),
        .per_iow_n (per_iow_n),
        .per_off   (per_off)
    );

    // Behavioural model, evaluated at each rising edge from the settled inputs.
    always @(posedge clk) begin
        int  a;
        bit  io, in_exp, in_per;
        a = int'(addr);
        if (!rst_n) begin
            m_ack = 1'b0;
            x_exp = 1'b1; x_per = 1'b1; x_ior = 1'b1; x_iow = 1'b1; x_off = 6'd0;
        end else begin
            io     = (iorq_n == 1'b0) && (m1_n == 1'b1) && !m_ack;        // R1, R9
            in_exp = (a >= 64 && a <= 127) || (a >= 192 && a <= 215);    // R2
            in_per = (a >= 128 && a <= 191);                              // R3
            x_exp  = !(io && in_exp);
            x_per  = !(io && in_per);
            x_ior  = !(io && in_per && e_clk && !rd_n && wr_n);           // R6, R8
            x_iow  = !(io && in_per && e_clk && !wr_n && rd_n);           // R7, R8
            x_off  = (io && in_per) ? 6'(a % 64) : 6'd0;                 // R5
            if (iorq_n) m_ack = 1'b0;
            else if (!m1_n) m_ack = 1'b1;
        end
    end

    task automatic cmp(input string req, input string nm, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s actual=%0h expected=%0h (addr=%0h t=%0t)", req, nm, act, exp, addr, $time);
        end
    endtask

    task automatic check_all();
        cmp("R2", "exp_cs_n",  int'(exp_cs_n),  int'(x_exp));
        cmp("R3", "per_cs_n",  int'(per_cs_n),  int'(x_per));
        cmp("R6", "per_ior_n", int'(per_ior_n), int'(x_ior));
        cmp("R7", "per_iow_n", int'(per_iow_n), int'(x_iow));
        cmp("R5", "per_off",   int'(per_off),   int'(x_off));
    endtask

    // one cycle: check the outputs of the last edge, then apply new inputs
    task automatic step(input logic [7:0] a, input logic iq, input logic m1,
                        input logic rd, input logic wr, input logic e);
        @(negedge clk);
        check_all();
        addr = a; iorq_n = iq; m1_n = m1; rd_n = rd; wr_n = wr; e_clk = e;
    endtask

    task automatic idle();
        step(addr, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    initial begin
        // R10: reset state
        repeat (3) step(8'hA0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check_all();
        rst_n = 1'b1;
        idle();

        // R1..R6, R4: read sweep across every address
        for (int i = 0; i < 256; i++) begin
            step(8'(i), 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
            idle();
        end

        // R7: write sweep
        for (int i = 0; i < 256; i += 3) begin
            step(8'(i), 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
            idle();
        end

        // R6, R7: E low means select without strobe, then E rises
        step(8'h80, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        step(8'h80, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        step(8'hBF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        step(8'hBF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        idle();

        // R8: both data strobes low
        step(8'h90, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        step(8'h55, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        idle();

        // R1: opcode fetch with IO request high
        step(8'hA5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        idle();

        // R9: acknowledge, then m1 rises while iorq stays low (same-cycle case)
        step(8'h85, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        step(8'h85, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        step(8'h45, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        step(8'hC3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        idle();
        // R9: after release a clean read works again
        step(8'h9A, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        step(8'h9A, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        idle();

        // R9: acknowledge directly followed by iorq high then a new read
        step(8'hB0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        step(8'hB0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        step(8'hB1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        idle();

        // R10: reset in the middle of an access and inside an acknowledge
        step(8'h88, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        step(8'h88, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check_all();
        rst_n = 1'b0;
        step(8'h88, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check_all();
        rst_n = 1'b1;
        step(8'h88, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        step(8'hD7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        step(8'hD8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        idle();
        idle();

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            misses++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule